// File: doc/BRIEF.md
# Spatio-Temporal Grayscale Dither Engine

The block turns a stream of 3-bit gray pixels into 1-bit monochrome pixels for a display that can only show on or off. Each intermediate gray level is drawn as a small on/off pattern that repeats across columns, across lines and across successive frames. The eye averages the pattern into an apparent shade. Software loads every pattern into a small table.

The table has one 19-bit word per (frame slot, gray level) pair. The low 16 bits are a 4×4 spatial pattern. The top 3 bits of a gray level's frame-slot-0 word choose its pattern period in each dimension, either 3 or 4. Three position counters follow the pixel stream by means of line-start and frame-start strobes. For every valid pixel the block picks one pattern bit and registers it, so the result appears one cycle later.

Top module: `dith_engine`

## Requirements
- R1: The table holds 32 words of 19 bits. The word index is `{frame_slot[1:0], gray[2:0]}`. A write with `cfg_we` high stores `cfg_wdata` at `cfg_addr` and is seen by pixels from the next cycle on. A pixel presented in the same cycle as a write to the word it reads uses the old contents.
- R2: Gray value 0 always gives output 0, and gray value 7 always gives output 1, whatever the table holds.
- R3: For gray values 1 to 6, the output bit is bit `{v,h}` (v in bits 3:2, h in bits 1:0) of word `{f, gray}`. Here h, v and f are the pixel's folded column, line and frame positions.
- R4: The periods are read from bits 18:16 of word `{2'b00, gray}`. Bit 16 set gives a column period of 4 and clear gives 3. Bit 17 does the same for the line period, and bit 18 for the frame period.
- R5: A valid pixel that carries line-start or frame-start is in column 0. Each later valid pixel is one column further on. The column is folded by the selected period, so for a fixed gray level it counts 0,1,2,0 or 0,1,2,3,0.
- R6: A frame-start pixel is in line 0. A line-start pixel without frame-start is one line further on. A frame-start pixel is one frame further on, and the first frame-start after reset is frame 0. Lines and frames fold by their periods in the same way as columns.
- R7: `dot_valid` is `pix_valid` delayed by one cycle. `dot_out` is the registered result for the pixel that was valid one cycle earlier.
- R8: While `pix_valid` is low, both strobes and the gray input are ignored and the positions are kept.
- R9: Reset clears `dot_valid` and `dot_out` and restarts all positions. It leaves the table contents as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_addr | input | 5 | Table word index {frame slot, gray} |
| cfg_wdata | input | 19 | Word: bits 18:16 periods, 15:0 pattern |
| pix_valid | input | 1 | Input pixel present |
| pix_line_start | input | 1 | Pixel is first of a line |
| pix_frame_start | input | 1 | Pixel is first of a frame |
| pix_gray | input | 3 | Gray level |
| dot_valid | output | 1 | Output pixel present |
| dot_out | output | 1 | Dithered output bit |

## Verification
The assertions take for granted that the strobes only matter alongside `pix_valid`, and that `cfg_addr` is a known value whenever `cfg_we` is high. The bench drives the strobes only together with a valid pixel, except in one deliberate idle cycle that tests R8. It drives every write address explicitly. Table writes happen before the pixel stream starts, except for one planned write that lands in the same cycle as a read of the same word.

// File: rtl/dith_pkg.sv
package dith_pkg;
    localparam int GRAY_W   = 3;
    localparam int SLOT_W   = 2;
    localparam int POS_W    = 2;
    localparam int PAT_BITS = 1 << (2 * POS_W);
    localparam int PER_BITS = 3;
    localparam int WORD_W   = PAT_BITS + PER_BITS;
    localparam int ADDR_W   = SLOT_W + GRAY_W;
    localparam int DEPTH    = 1 << ADDR_W;
    localparam int RAW_W    = 4;
    localparam int RAW_TOP  = 11;

    typedef struct packed {
        logic [RAW_W-1:0] h_next;
        logic [RAW_W-1:0] v_cur;
        logic [RAW_W-1:0] f_cur;
    } ctr_state_t;

    typedef struct packed {
        logic vld;
        logic bit_o;
    } out_state_t;

    function automatic logic [RAW_W-1:0] raw_step(input logic [RAW_W-1:0] raw);
        return (raw == RAW_W'(RAW_TOP)) ? '0 : raw + RAW_W'(1);
    endfunction

    function automatic logic [POS_W-1:0] fold(input logic [RAW_W-1:0] raw, input logic four);
        logic [RAW_W-1:0] r;
        r = four ? (raw & RAW_W'(3)) : (raw % RAW_W'(3));
        return r[POS_W-1:0];
    endfunction
endpackage

// File: rtl/dith_counters.sv
module dith_counters
    import dith_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_valid,
    input  logic             line_start,
    input  logic             frame_start,
    output logic [RAW_W-1:0] h_raw,
    output logic [RAW_W-1:0] v_raw,
    output logic [RAW_W-1:0] f_raw
);
    ctr_state_t state_d, state_q;

    always_comb begin
        h_raw = (line_start || frame_start) ? '0 : state_q.h_next;
        if (frame_start)     v_raw = '0;
        else if (line_start) v_raw = raw_step(state_q.v_cur);
        else                 v_raw = state_q.v_cur;
        f_raw = frame_start ? raw_step(state_q.f_cur) : state_q.f_cur;

        state_d = state_q;
        if (pix_valid) begin
            state_d.h_next = raw_step(h_raw);
            state_d.v_cur  = v_raw;
            state_d.f_cur  = f_raw;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.h_next <= '0;
            state_q.v_cur  <= '0;
            state_q.f_cur  <= RAW_W'(RAW_TOP);
        end else begin
            state_q <= state_d;
        end
    end

    a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> $stable(state_q));
    a_r5_line_restart: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid && (line_start || frame_start) |=> state_q.h_next == RAW_W'(1));
    a_r6_frame_line0: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid && frame_start |=> state_q.v_cur == '0);
endmodule

// File: rtl/dith_table.sv
module dith_table
    import dith_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] per_addr,
    input  logic [ADDR_W-1:0] pat_addr,
    output logic [WORD_W-1:0] per_word,
    output logic [WORD_W-1:0] pat_word
);
    logic [WORD_W-1:0] mem_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        logic [WORD_W-1:0] word_d;
        always_comb begin
            word_d = mem_q[i];
            if (wr_en && wr_addr == ADDR_W'(i)) word_d = wr_data;
        end
        always_ff @(posedge clk) begin
            mem_q[i] <= word_d;
        end
    end

    always_comb begin
        per_word = mem_q[per_addr];
        pat_word = mem_q[pat_addr];
    end

    a_r1_addr_known: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !$isunknown(wr_addr));
endmodule

// File: rtl/dith_select.sv
module dith_select
    import dith_pkg::*;
(
    input  logic [GRAY_W-1:0] gray,
    input  logic [RAW_W-1:0]  h_raw,
    input  logic [RAW_W-1:0]  v_raw,
    input  logic [RAW_W-1:0]  f_raw,
    input  logic [WORD_W-1:0] per_word,
    input  logic [WORD_W-1:0] pat_word,
    output logic [SLOT_W-1:0] slot,
    output logic              dot
);
    logic [PER_BITS-1:0] per;
    logic [POS_W-1:0]    h_pos, v_pos;
    logic [PAT_BITS-1:0] pattern;

    always_comb begin
        per     = per_word[WORD_W-1 -: PER_BITS];
        h_pos   = fold(h_raw, per[0]);
        v_pos   = fold(v_raw, per[1]);
        slot    = fold(f_raw, per[2]);
        pattern = pat_word[PAT_BITS-1:0];
        if (gray == '0)                   dot = 1'b0;
        else if (gray == {GRAY_W{1'b1}})  dot = 1'b1;
        else                              dot = pattern[{v_pos, h_pos}];
    end
endmodule

// File: rtl/dith_engine.sv
module dith_engine
    import dith_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [WORD_W-1:0] cfg_wdata,
    input  logic              pix_valid,
    input  logic              pix_line_start,
    input  logic              pix_frame_start,
    input  logic [GRAY_W-1:0] pix_gray,
    output logic              dot_valid,
    output logic              dot_out
);
    logic [RAW_W-1:0]  h_raw, v_raw, f_raw;
    logic [WORD_W-1:0] per_word, pat_word;
    logic [SLOT_W-1:0] slot;
    logic              dot;
    out_state_t        out_d, out_q;

    dith_counters u_ctr (
        .clk         (clk),
        .rst_n       (rst_n),
        .pix_valid   (pix_valid),
        .line_start  (pix_line_start),
        .frame_start (pix_frame_start),
        .h_raw       (h_raw),
        .v_raw       (v_raw),
        .f_raw       (f_raw)
    );

    dith_table u_tab (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_addr  (cfg_addr),
        .wr_data  (cfg_wdata),
        .per_addr ({SLOT_W'(0), pix_gray}),
        .pat_addr ({slot, pix_gray}),
        .per_word (per_word),
        .pat_word (pat_word)
    );

    dith_select u_sel (
        .gray     (pix_gray),
        .h_raw    (h_raw),
        .v_raw    (v_raw),
        .f_raw    (f_raw),
        .per_word (per_word),
        .pat_word (pat_word),
        .slot     (slot),
        .dot      (dot)
    );

    always_comb begin
        out_d.vld   = pix_valid;
        out_d.bit_o = pix_valid ? dot : 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign dot_valid = out_q.vld;
    assign dot_out   = out_q.bit_o;

    a_r7_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> dot_valid);
    a_r7_idle_delay: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> !dot_valid);
    a_r2_black: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid && pix_gray == '0 |=> !dot_out);
    a_r2_white: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid && pix_gray == {GRAY_W{1'b1}} |=> dot_out);
endmodule

// File: tb/sim_dith_engine.sv
`timescale 1ns/1ps
module sim_dith_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [18:0] cfg_wdata = '0;
    logic        pix_valid = 1'b0;
    logic        pix_ls = 1'b0;
    logic        pix_fs = 1'b0;
    logic [2:0]  pix_gray = '0;
    logic        dot_valid, dot_out;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    dith_engine u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .pix_valid(pix_valid), .pix_line_start(pix_ls),
        .pix_frame_start(pix_fs), .pix_gray(pix_gray),
        .dot_valid(dot_valid), .dot_out(dot_out)
    );

    // {frame_start, line_start, gray[2:0], expected bit}
    localparam logic [5:0] VEC [17] = '{
        {1'b1,1'b0,3'd2,1'b1}, {1'b0,1'b0,3'd2,1'b1}, {1'b0,1'b0,3'd3,1'b0},
        {1'b0,1'b0,3'd3,1'b1}, {1'b0,1'b0,3'd5,1'b1}, {1'b0,1'b0,3'd0,1'b0},
        {1'b0,1'b0,3'd7,1'b1}, {1'b0,1'b1,3'd2,1'b0}, {1'b0,1'b0,3'd5,1'b1},
        {1'b0,1'b1,3'd5,1'b0}, {1'b0,1'b1,3'd2,1'b1}, {1'b1,1'b0,3'd2,1'b0},
        {1'b0,1'b1,3'd2,1'b1}, {1'b1,1'b0,3'd2,1'b0}, {1'b1,1'b0,3'd2,1'b1},
        {1'b0,1'b0,3'd5,1'b0}, {1'b1,1'b0,3'd5,1'b1}
    };
    localparam string VREQ [17] = '{
        "R6", "R5", "R5", "R5", "R4", "R2", "R2", "R3", "R3",
        "R3", "R6", "R6", "R6", "R6", "R6", "R4", "R4"
    };

    task automatic check(input logic ev, input logic eb, input string req);
        checks++;
        if (dot_valid !== ev || dot_out !== eb) begin
            fails++;
            $display("FAIL %s: got valid=%b bit=%b, expected valid=%b bit=%b",
                     req, dot_valid, dot_out, ev, eb);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [18:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pix(input logic v, input logic fs, input logic ls, input logic [2:0] g);
        pix_valid = v; pix_fs = fs; pix_ls = ls; pix_gray = g;
        @(negedge clk);
        pix_valid = 1'b0; pix_fs = 1'b0; pix_ls = 1'b0;
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            checks++; fails++;
            $display("FAIL watchdog: got %0d cycles, expected under 5000", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(1'b0, 1'b0, "R9");
        rst_n = 1'b1;
        @(negedge clk);
        check(1'b0, 1'b0, "R9");
        for (int f = 0; f < 4; f++) begin
            // gray 2: periods h4 v3 f3, lit line equals frame slot
            wr({f[1:0], 3'd2}, {(f == 0) ? 3'b001 : 3'b000, 16'h000F << (4 * f)});
            // gray 3: periods 3/3/3, lit when column 0
            wr({f[1:0], 3'd3}, {3'b000, 16'h1111});
            // gray 5: periods 4/4/4, diagonal
            wr({f[1:0], 3'd5}, {3'b111, 16'h8421});
            wr({f[1:0], 3'd0}, 19'h7FFFF);
            wr({f[1:0], 3'd7}, 19'h00000);
        end
        for (int i = 0; i < 17; i++) begin
            pix(1'b1, VEC[i][5], VEC[i][4], VEC[i][3:1]);
            check(1'b1, VEC[i][0], VREQ[i]);
        end
        // R7: idle cycle gives no output valid
        pix(1'b0, 1'b0, 1'b0, 3'd2);
        check(1'b0, 1'b0, "R7");
        // R1: frame slot 2 for gray 3 is written while being read
        cfg_we = 1'b1; cfg_addr = {2'd2, 3'd3}; cfg_wdata = '0;
        pix(1'b1, 1'b1, 1'b0, 3'd3);
        cfg_we = 1'b0;
        check(1'b1, 1'b1, "R1");
        pix(1'b1, 1'b0, 1'b0, 3'd3);
        check(1'b1, 1'b0, "R5");
        pix(1'b1, 1'b0, 1'b0, 3'd3);
        check(1'b1, 1'b0, "R5");
        pix(1'b1, 1'b0, 1'b0, 3'd3);
        check(1'b1, 1'b0, "R1");
        // R8: strobes without valid are ignored
        pix(1'b0, 1'b1, 1'b1, 3'd2);
        check(1'b0, 1'b0, "R8");
        pix(1'b1, 1'b0, 1'b0, 3'd2);
        check(1'b1, 1'b0, "R8");
        // R9: reset mid-stream restarts positions and keeps the table
        rst_n = 1'b0;
        pix(1'b1, 1'b0, 1'b0, 3'd7);
        check(1'b0, 1'b0, "R9");
        rst_n = 1'b1;
        pix(1'b1, 1'b1, 1'b0, 3'd2);
        check(1'b1, 1'b1, "R9");
        pix(1'b1, 1'b0, 1'b1, 3'd2);
        check(1'b1, 1'b0, "R3");
        finish_run();
    end
endmodule